// File: doc/BRIEF.md
# Upstream DMA Buffer Fill Controller

This block serves one device-to-host stream. Words arrive from a user FIFO through a valid/ready pair. The block writes them into a ring of host DMA buffers, one buffer after another. For each word it accepts, it issues one DMA write beat that carries the data and a byte address within the ring. Buffers are filled in ascending index order and the index wraps around at the end of the ring.

A buffer is handed to the host, or submitted, in one of two ways. The first is automatic: the block submits a buffer as soon as its last word is written. The second is on request: after the host raises a flush, the block submits a partly filled buffer at the first chance it gets. Each submission produces one request to the message queue, naming the buffer and stating how many valid bytes it holds. A submitted buffer belongs to the host until the host returns it through a control write, and while the next buffer to fill is still held by the host, the block stalls the FIFO.

When the channel goes from holding no data to holding some, the block emits a single notice so that the host can poll. A configuration input can suppress this notice.

Top module: `usp_fill_ctrl`

## Requirements
- R1: A word accepted in a cycle (inValid and inReady both high at the clock edge) appears one cycle later as a dmaValid beat with the same data, at byte address bufIndex*BUF_BYTES + wordOffset*(WORD_W/8).
- R2: Buffers are filled and submitted in ascending index order starting from 0, and the index wraps from NUM_BUFS-1 to 0.
- R3: The cycle after the word that fills the last slot of a buffer is accepted, subValid pulses for one cycle with subIdx set to that buffer and subBytes set to BUF_BYTES.
- R4: After a one-cycle flushReq pulse, if the current buffer holds data, inReady is low in the next cycle, and in the cycle after that subValid pulses with subBytes equal to the number of words held times WORD_W/8. Filling then continues in the next buffer. This is the only way a partial buffer is submitted.
- R5: A flush that finds the current buffer empty submits nothing and is dropped, so later words do not cause a partial submission.
- R6: A submitted buffer is held by the host, and inReady is low for as long as the current buffer is held.
- R7: A relWrite pulse returns buffer relIdx to the block. A release of a buffer that is not held has no effect.
- R8: When noticeEn is high, neValid pulses one cycle after the first word accepted while the channel held no data, which means the current buffer was empty and no buffer was held by the host.
- R9: After a notice, no further notice is sent until every submitted buffer has been released while the current buffer is empty.
- R10: When noticeEn is low at the accept that would trigger a notice, no notice is sent and the trigger is still used up.
- R11: After reset, inReady is high and dmaValid, subValid and neValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | WORD_W | Stream word from the user FIFO |
| inValid | input | 1 | Stream word present |
| inReady | output | 1 | Block can take a word this cycle |
| flushReq | input | 1 | Host flush command, one-cycle pulse |
| relWrite | input | 1 | Host buffer release strobe |
| relIdx | input | log2(NUM_BUFS) | Index of the buffer being released |
| noticeEn | input | 1 | Enables the nonempty notice |
| dmaValid | output | 1 | DMA write beat present |
| dmaAddr | output | log2(NUM_BUFS*BUF_BYTES) | Byte address of the beat within the ring |
| dmaData | output | WORD_W | Beat data |
| subValid | output | 1 | Submit request to the message queue |
| subIdx | output | log2(NUM_BUFS) | Index of the submitted buffer |
| subBytes | output | log2(BUF_BYTES)+1 | Valid bytes in the submitted buffer |
| neValid | output | 1 | Nonempty notice request |

## Verification
The assertions assume that the DMA engine and the message queue accept every beat and every request in the cycle it is issued, and that flushReq and relWrite are single-cycle strobes. The bench never applies backpressure on either output side, and it drives flushes, releases and the notice enable as per-cycle random strobes. Releases pick random indices, so some of them target buffers the host does not hold. Directed phases fill the whole ring until it stalls, flush both an empty buffer and a partial one, and check that the notice stays silent while buffers are still held.

// File: rtl/usp_fill_pkg.sv
package usp_fill_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accept;   // take the word on inData into the current buffer
    logic submit;   // close the current buffer and move to the next one
    logic notice;   // raise the nonempty notice next cycle
  } fillStrobe_t;

endpackage

// File: rtl/usp_fill_control.sv
module usp_fill_control
  import usp_fill_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int WORDS    = 8,
  localparam int IDX_W   = $clog2(NUM_BUFS),
  localparam int OFF_W   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             flushReq,
  input  logic             relWrite,
  input  logic [IDX_W-1:0] relIdx,
  input  logic             noticeEn,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [OFF_W-1:0] fillCount,
  output logic             inReady,
  output fillStrobe_t      strobe
);

  localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(WORDS - 1);

  logic [NUM_BUFS-1:0] hostOwned;
  logic                flushPend;
  logic                armed;

  logic curHeld;
  logic hasData;
  logic flushHold;
  logic accept;
  logic fullSub;
  logic effArmed;

  always_comb begin
    curHeld   = hostOwned[curIdx];
    hasData   = (fillCount != '0);
    flushHold = flushPend && hasData;
    inReady   = !curHeld && !flushHold;
    accept    = inValid && inReady;
    fullSub   = accept && (fillCount == LAST_SLOT);
    effArmed  = armed || ((hostOwned == '0) && !hasData);

    strobe.accept = accept;
    strobe.submit = fullSub || flushHold;
    strobe.notice = accept && effArmed && noticeEn;
  end

  // ownership flag per buffer: set on submit, cleared by host release
  for (genvar g = 0; g < NUM_BUFS; g++) begin : gOwn
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hostOwned[g] <= 1'b0;
      end else if (strobe.submit && (curIdx == IDX_W'(g))) begin
        hostOwned[g] <= 1'b1;
      end else if (relWrite && (relIdx == IDX_W'(g))) begin
        hostOwned[g] <= 1'b0;
      end
    end
  end

  // a pending flush is always resolved in the cycle it is seen:
  // either the partial buffer goes out or there is nothing to send
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPend <= 1'b0;
      armed     <= 1'b1;
    end else begin
      flushPend <= flushReq;
      armed     <= accept ? 1'b0 : effArmed;
    end
  end

endmodule

// File: rtl/usp_fill_datapath.sv
module usp_fill_datapath
  import usp_fill_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 32,
  parameter int NUM_BUFS  = 4,
  localparam int WB       = WORD_W / 8,
  localparam int WORDS    = BUF_BYTES / WB,
  localparam int IDX_W    = $clog2(NUM_BUFS),
  localparam int OFF_W    = $clog2(WORDS),
  localparam int ADDR_W   = $clog2(NUM_BUFS * BUF_BYTES),
  localparam int BYTE_W   = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobe_t       strobe,
  input  logic [WORD_W-1:0] inData,
  output logic [IDX_W-1:0]  curIdx,
  output logic [OFF_W-1:0]  fillCount,
  output logic              dmaValid,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [WORD_W-1:0] dmaData,
  output logic              subValid,
  output logic [IDX_W-1:0]  subIdx,
  output logic [BYTE_W-1:0] subBytes,
  output logic              neValid
);

  logic [ADDR_W-1:0] beatAddr;
  logic [BYTE_W-1:0] wordsHeld;

  always_comb begin
    beatAddr  = ADDR_W'(curIdx) * ADDR_W'(BUF_BYTES)
              + ADDR_W'(fillCount) * ADDR_W'(WB);
    wordsHeld = BYTE_W'(fillCount) + BYTE_W'(strobe.accept);
  end

  // ring position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx    <= '0;
      fillCount <= '0;
    end else if (strobe.submit) begin
      curIdx    <= curIdx + 1'b1;
      fillCount <= '0;
    end else if (strobe.accept) begin
      fillCount <= fillCount + 1'b1;
    end
  end

  // DMA beat stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaValid <= 1'b0;
      dmaAddr  <= '0;
      dmaData  <= '0;
    end else begin
      dmaValid <= strobe.accept;
      if (strobe.accept) begin
        dmaAddr <= beatAddr;
        dmaData <= inData;
      end
    end
  end

  // message queue requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subValid <= 1'b0;
      subIdx   <= '0;
      subBytes <= '0;
      neValid  <= 1'b0;
    end else begin
      subValid <= strobe.submit;
      neValid  <= strobe.notice;
      if (strobe.submit) begin
        subIdx   <= curIdx;
        subBytes <= wordsHeld * BYTE_W'(WB);
      end
    end
  end

endmodule

// File: rtl/usp_fill_ctrl.sv
module usp_fill_ctrl
  import usp_fill_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 32,
  parameter int NUM_BUFS  = 4,
  localparam int WB       = WORD_W / 8,
  localparam int WORDS    = BUF_BYTES / WB,
  localparam int IDX_W    = $clog2(NUM_BUFS),
  localparam int OFF_W    = $clog2(WORDS),
  localparam int ADDR_W   = $clog2(NUM_BUFS * BUF_BYTES),
  localparam int BYTE_W   = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              flushReq,
  input  logic              relWrite,
  input  logic [IDX_W-1:0]  relIdx,
  input  logic              noticeEn,
  output logic              dmaValid,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [WORD_W-1:0] dmaData,
  output logic              subValid,
  output logic [IDX_W-1:0]  subIdx,
  output logic [BYTE_W-1:0] subBytes,
  output logic              neValid
);

  fillStrobe_t      strobe;
  logic [IDX_W-1:0] curIdx;
  logic [OFF_W-1:0] fillCount;

  usp_fill_control #(
    .NUM_BUFS (NUM_BUFS),
    .WORDS    (WORDS)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .flushReq  (flushReq),
    .relWrite  (relWrite),
    .relIdx    (relIdx),
    .noticeEn  (noticeEn),
    .curIdx    (curIdx),
    .fillCount (fillCount),
    .inReady   (inReady),
    .strobe    (strobe)
  );

  usp_fill_datapath #(
    .WORD_W    (WORD_W),
    .BUF_BYTES (BUF_BYTES),
    .NUM_BUFS  (NUM_BUFS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .curIdx    (curIdx),
    .fillCount (fillCount),
    .dmaValid  (dmaValid),
    .dmaAddr   (dmaAddr),
    .dmaData   (dmaData),
    .subValid  (subValid),
    .subIdx    (subIdx),
    .subBytes  (subBytes),
    .neValid   (neValid)
  );

endmodule

// File: rtl/usp_fill_checker.sv
module usp_fill_checker #(
  parameter int BUF_BYTES = 32,
  parameter int NUM_BUFS  = 4,
  localparam int IDX_W    = $clog2(NUM_BUFS),
  localparam int BYTE_W   = $clog2(BUF_BYTES) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              flushReq,
  input logic              noticeEn,
  input logic              dmaValid,
  input logic              subValid,
  input logic [IDX_W-1:0]  subIdx,
  input logic [BYTE_W-1:0] subBytes,
  input logic              neValid
);

  logic [IDX_W-1:0] expIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expIdx <= '0;
    end else if (subValid) begin
      expIdx <= expIdx + 1'b1;
    end
  end

  // R1
  beat_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> $past(inValid && inReady));

  // R2
  submit_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> (subIdx == expIdx));

  // R3
  submit_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> ((subBytes != '0) && (subBytes <= BYTE_W'(BUF_BYTES))));

  // R4
  partial_needs_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && (subBytes != BYTE_W'(BUF_BYTES))) |-> $past(flushReq, 2));

  // R8
  notice_with_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    neValid |-> dmaValid);

  // R10
  notice_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    neValid |-> $past(noticeEn));

endmodule

bind usp_fill_ctrl usp_fill_checker #(
  .BUF_BYTES (BUF_BYTES),
  .NUM_BUFS  (NUM_BUFS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .flushReq (flushReq),
  .noticeEn (noticeEn),
  .dmaValid (dmaValid),
  .subValid (subValid),
  .subIdx   (subIdx),
  .subBytes (subBytes),
  .neValid  (neValid)
);

// File: tb/tb_usp_fill_ctrl.sv
`timescale 1ns/1ps
module tb_usp_fill_ctrl;

  localparam int WORD_W    = 32;
  localparam int BUF_BYTES = 32;
  localparam int NUM_BUFS  = 4;
  localparam int WB        = WORD_W / 8;
  localparam int WORDS     = BUF_BYTES / WB;
  localparam int IDX_W     = $clog2(NUM_BUFS);
  localparam int ADDR_W    = $clog2(NUM_BUFS * BUF_BYTES);
  localparam int BYTE_W    = $clog2(BUF_BYTES) + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [WORD_W-1:0] inData = '0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic              flushReq = 1'b0;
  logic              relWrite = 1'b0;
  logic [IDX_W-1:0]  relIdx = '0;
  logic              noticeEn = 1'b1;
  logic              dmaValid;
  logic [ADDR_W-1:0] dmaAddr;
  logic [WORD_W-1:0] dmaData;
  logic              subValid;
  logic [IDX_W-1:0]  subIdx;
  logic [BYTE_W-1:0] subBytes;
  logic              neValid;

  always #2.5 clk = ~clk;

  usp_fill_ctrl #(.WORD_W(WORD_W), .BUF_BYTES(BUF_BYTES), .NUM_BUFS(NUM_BUFS)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .flushReq(flushReq), .relWrite(relWrite), .relIdx(relIdx), .noticeEn(noticeEn),
    .dmaValid(dmaValid), .dmaAddr(dmaAddr), .dmaData(dmaData),
    .subValid(subValid), .subIdx(subIdx), .subBytes(subBytes), .neValid(neValid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state derived from the requirements
  int mCur, mFill, mArmed, mFp;
  bit [NUM_BUFS-1:0] mOwned;
  int eDma, eAddr, eData, eSub, eIdx, eBytes, eNe;
  int seq = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expReady();
    return (!mOwned[mCur] && !(mFp != 0 && mFill != 0)) ? 1 : 0;
  endfunction

  function automatic int emptyChannel();
    return (mOwned == '0 && mFill == 0) ? 1 : 0;
  endfunction

  // one cycle: check outputs of previous edge, drive inputs, advance model
  task automatic cycle(bit v, int d, bit fl, bit rel, int ri, bit ne);
    int acc, effA, doSub;
    @(negedge clk);
    check("R1 dmaValid", int'(dmaValid), eDma);
    if (eDma != 0) begin
      check("R1 R2 dmaAddr", int'(dmaAddr), eAddr);
      check("R1 dmaData", int'(dmaData), eData);
    end
    check("R3 R4 R5 subValid", int'(subValid), eSub);
    if (eSub != 0) begin
      check("R2 subIdx", int'(subIdx), eIdx);
      check("R3 R4 subBytes", int'(subBytes), eBytes);
    end
    check("R8 R9 R10 neValid", int'(neValid), eNe);
    check("R6 R7 inReady", int'(inReady), expReady());
    inValid  = v;
    inData   = WORD_W'(d);
    flushReq = fl;
    relWrite = rel;
    relIdx   = IDX_W'(ri);
    noticeEn = ne;
    acc   = (v && expReady() != 0) ? 1 : 0;
    effA  = (mArmed != 0 || emptyChannel() != 0) ? 1 : 0;
    eDma  = acc;
    eAddr = mCur * BUF_BYTES + mFill * WB;
    eData = d;
    eNe   = (acc != 0 && effA != 0 && ne) ? 1 : 0;
    mArmed = (acc != 0) ? 0 : effA;
    doSub = ((acc != 0 && mFill == WORDS - 1) || (mFp != 0 && mFill != 0)) ? 1 : 0;
    eSub   = doSub;
    eIdx   = mCur;
    eBytes = (mFill + acc) * WB;
    if (rel) mOwned[ri] = 1'b0;
    if (doSub != 0) begin
      mOwned[mCur] = 1'b1;
      mCur  = (mCur + 1) % NUM_BUFS;
      mFill = 0;
    end else begin
      mFill = mFill + acc;
    end
    mFp = fl ? 1 : 0;
  endtask

  task automatic word();
    seq++;
    cycle(1'b1, seq * 32'h01010101 + 7, 1'b0, 1'b0, 0, 1'b1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 0, 1'b0, 1'b0, 0, 1'b1);
  endtask

  task automatic releaseAll();
    for (int i = 0; i < NUM_BUFS; i++) cycle(1'b0, 0, 1'b0, 1'b1, i, 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    mCur = 0; mFill = 0; mArmed = 1; mFp = 0; mOwned = '0;
    eDma = 0; eAddr = 0; eData = 0; eSub = 0; eIdx = 0; eBytes = 0; eNe = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 inReady", int'(inReady), 1);
    check("R11 dmaValid", int'(dmaValid), 0);
    check("R11 subValid", int'(subValid), 0);
    check("R11 neValid", int'(neValid), 0);

    // R8 first words raise one notice, then R4 partial flush of 3 words
    word(); word(); word();
    cycle(1'b0, 0, 1'b1, 1'b0, 0, 1'b1);
    cycle(1'b1, 99, 1'b0, 1'b0, 0, 1'b1);
    check("R4 inReady held during flush", int'(inReady), 0);
    idle(1);
    check("R4 partial submit", int'(subValid), 1);
    check("R4 partial bytes", int'(subBytes), 3 * WB);
    idle(1);

    // R9 buffer 0 still held: new data must not raise a notice
    word();
    idle(1);
    check("R9 no notice while held", int'(neValid), 0);
    // R5 flush of an empty buffer after finishing buffer 1
    for (int i = 1; i < WORDS; i++) word();
    cycle(1'b0, 0, 1'b1, 1'b0, 0, 1'b1);
    idle(3);
    check("R5 no submit on empty flush", int'(subValid), 0);

    // R6 fill the remaining ring until it stalls
    for (int i = 0; i < 3 * WORDS; i++) word();
    idle(2);
    check("R6 stall when ring held", int'(inReady), 0);
    // R7 release of the held current buffer resumes
    cycle(1'b0, 0, 1'b0, 1'b1, mCur, 1'b1);
    idle(1);
    check("R7 ready after release", int'(inReady), 1);
    releaseAll();
    idle(2);
    // R10 disabled notice still consumes the trigger
    cycle(1'b1, 5, 1'b0, 1'b0, 0, 1'b0);
    idle(1);
    check("R10 notice suppressed", int'(neValid), 0);
    word();
    idle(1);
    check("R10 trigger consumed", int'(neValid), 0);
    cycle(1'b0, 0, 1'b1, 1'b0, 0, 1'b1);
    idle(3);
    releaseAll();
    idle(2);
    // R9 re-armed once everything is back and empty
    word();
    idle(1);
    check("R9 notice after re-arm", int'(neValid), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 10) < 7, int'($urandom), ($urandom % 20) == 0,
            ($urandom % 5) == 0, int'($urandom % NUM_BUFS), ($urandom % 8) != 0);
    end
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule